// File: doc/BRIEF.md
# Sixteen-Pin I/O Bank with Interrupt Triggers

This block is one bank of general-purpose pins. A simple 16-bit register bus lets software set each pin's drive enable, output value and alternate-function selection. It also configures, per pin, whether an interrupt is raised on an edge or on a level, and of which polarity. Input pins are brought into the clock domain by a two-flop synchronizer. Their synchronized levels can be read back from a read-only register.

Per-pin detection results are collected in a pending register. An edge leaves its bit set until software clears the register. A level condition sets its bit again on every cycle that it holds. Pending bits that are not masked are ORed into one registered bank interrupt, which goes to a chip-level interrupt aggregator. The register bus has a read latency of one cycle. Writes take effect at the clock edge where they are presented.

Word addresses on the bus:

| Address | Register | Access |
|---|---|---|
| 0 | drive enable | read/write |
| 1 | output value | read/write |
| 2 | alternate-function select | read/write |
| 3 | interrupt mask | read/write |
| 4 | trigger kind | read/write |
| 5 | edge polarity | read/write |
| 6 | level polarity | read/write |
| 7 | pending | read, clear by writing zero |
| 8 | pin levels | read only |

Top module: `gpio_bank`

## Requirements
- R1: While reset is high and after it is released, the drive-enable, output, alternate-select, mask, trigger-kind, edge-polarity and level-polarity registers (addresses 0 to 6) read zero, and `bank_irq` is low during reset.
- R2: A write to address 0, 1 or 2 updates `pad_oe`, `pad_out` or `alt_sel` at that clock edge. A read of any address returns the stored value on `bus_rdata` after the next rising edge. A drive-enable bit of 1 means the pin is an output and 0 means it is an input.
- R3: Address 8 returns the pin levels after two synchronizer flops. Bit n always belongs to pin n.
- R4: A pin with trigger-kind bit 1 (edge) and edge-polarity bit 1 sets its pending bit on a 0-to-1 transition only.
- R5: A pin with trigger-kind bit 1 and edge-polarity bit 0 sets its pending bit on a 1-to-0 transition only.
- R6: An edge-set pending bit stays set after the pin returns to its former level, until the pending register is cleared.
- R7: A pin with trigger-kind bit 0 (level) and level-polarity bit 1 sets its pending bit on every cycle its synchronized input is high. A clear while the condition holds leaves the bit set.
- R8: A pin with trigger-kind bit 0 and level-polarity bit 0 sets its pending bit while its synchronized input is low, and not while it is high.
- R9: A mask bit of 1 keeps that pin's pending bit from raising `bank_irq`, but the pending bit is still recorded. A mask bit of 0 lets it through.
- R10: `bank_irq` is a register that holds, one cycle later, the OR of the pending bits ANDed with the inverted mask.
- R11: A write of 0x0000 to address 7 clears all pending bits, except those set by a detection in that same cycle. A write of any nonzero value to address 7 changes nothing.
- R12: Writes to address 8 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after a read |
| pins_in | input | 16 | Asynchronous pin inputs |
| pad_out | output | 16 | Output values to the pads |
| pad_oe | output | 16 | Per-pin output enable (1 = drive) |
| alt_sel | output | 16 | Stored alternate-function selection |
| bank_irq | output | 1 | Combined bank interrupt |

## Verification
The detection path is driven with isolated single-pin transitions in each direction for both edge polarities. Driving the opposite transition shows that the polarity bit really selects a direction and is not just a change detector. Level pins are held active across a clear and then released, which separates a level's re-assertion from an edge's sticky behaviour. Masked and unmasked pending bits, and zero versus nonzero writes to the pending register, separate recording from signalling and a true clear from a plain write.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_DRIVE  = 4'd0,
    A_OUTVAL = 4'd1,
    A_ALTSEL = 4'd2,
    A_MASK   = 4'd3,
    A_KIND   = 4'd4,
    A_EPOL   = 4'd5,
    A_LPOL   = 4'd6,
    A_PEND   = 4'd7,
    A_LEVELS = 4'd8
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else if (s == 0) chain[s] <= d_async;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] kind,
  input  logic [W-1:0] epol,
  input  logic [W-1:0] lpol,
  output logic [W-1:0] hit
);
  logic [W-1:0] last;

  always_ff @(posedge clk) begin
    if (rst) last <= '0;
    else     last <= cur;
  end

  generate
    for (genvar i = 0; i < W; i++) begin : g_pin
      logic rise, fall;
      always_comb begin
        rise = cur[i] & ~last[i];
        fall = ~cur[i] & last[i];
        if (kind[i]) hit[i] = epol[i] ? rise : fall;
        else         hit[i] = (cur[i] == lpol[i]);
      end
    end
  endgenerate
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_bank_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata,
  input  logic [W-1:0]      hit,
  input  logic [W-1:0]      levels,
  output logic [W-1:0]      drive,
  output logic [W-1:0]      outval,
  output logic [W-1:0]      altsel,
  output logic [W-1:0]      mask,
  output logic [W-1:0]      kind,
  output logic [W-1:0]      epol,
  output logic [W-1:0]      lpol,
  output logic [W-1:0]      pend,
  output logic              irq
);
  logic wen, ren, pend_clr;
  logic [W-1:0] rd_mux;

  assign wen      = sel & wr;
  assign ren      = sel & ~wr;
  assign pend_clr = wen && (addr == A_PEND) && (wdata == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      drive <= '0; outval <= '0; altsel <= '0; mask <= '0;
      kind  <= '0; epol   <= '0; lpol   <= '0;
    end else if (wen) begin
      case (addr)
        A_DRIVE:  drive  <= wdata;
        A_OUTVAL: outval <= wdata;
        A_ALTSEL: altsel <= wdata;
        A_MASK:   mask   <= wdata;
        A_KIND:   kind   <= wdata;
        A_EPOL:   epol   <= wdata;
        A_LPOL:   lpol   <= wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           pend <= '0;
    else if (pend_clr) pend <= hit;
    else               pend <= pend | hit;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(pend & ~mask);
  end

  always_comb begin
    case (addr)
      A_DRIVE:  rd_mux = drive;
      A_OUTVAL: rd_mux = outval;
      A_ALTSEL: rd_mux = altsel;
      A_MASK:   rd_mux = mask;
      A_KIND:   rd_mux = kind;
      A_EPOL:   rd_mux = epol;
      A_LPOL:   rd_mux = lpol;
      A_PEND:   rd_mux = pend;
      A_LEVELS: rd_mux = levels;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)      rdata <= '0;
    else if (ren) rdata <= rd_mux;
  end

  // R6: pending bits only drop on a clear
  p_pend_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !pend_clr |=> (($past(pend) & ~pend) == '0));

  // R11: after a clear only the same-cycle hits remain
  p_clear_r11: assert property (@(posedge clk) disable iff (rst)
    pend_clr |=> (pend == $past(hit)));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pins_in,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_oe,
  output logic [W-1:0]      alt_sel,
  output logic              bank_irq
);
  logic [W-1:0] levels, hit, mask, kind, epol, lpol, pend;

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_async(pins_in), .q_sync(levels));

  gpio_trig_detect #(.W(W)) u_det (
    .clk(clk), .rst(rst), .cur(levels), .kind(kind), .epol(epol),
    .lpol(lpol), .hit(hit));

  gpio_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .hit(hit), .levels(levels),
    .drive(pad_oe), .outval(pad_out), .altsel(alt_sel), .mask(mask),
    .kind(kind), .epol(epol), .lpol(lpol), .pend(pend), .irq(bank_irq));

  // R10: interrupt follows unmasked pending one cycle later
  p_irq_follow_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (bank_irq == $past(|(pend & ~mask))));

  // R9: nothing unmasked pending means no interrupt next cycle
  p_mask_block_r9: assert property (@(posedge clk) disable iff (rst)
    ((pend & ~mask) == '0) |=> !bank_irq);

  // R7: an active level condition is pending in the next cycle
  p_level_set_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(~kind & ~(levels ^ lpol)) & ~pend) == '0));
endmodule

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 0, rst = 1;
  logic bus_sel = 0, bus_wr = 0;
  logic [3:0] bus_addr = '0;
  logic [W-1:0] bus_wdata = '0, pins_in = '0;
  logic [W-1:0] bus_rdata, pad_out, pad_oe, alt_sel;
  logic bank_irq;

  int n_chk = 0, n_bad = 0;

  typedef struct { logic [W-1:0] exp; string tag; } item_t;
  item_t sb_q[$];
  logic rd_issued = 0, rd_fire = 0;

  gpio_bank dut (.clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pins_in(pins_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .alt_sel(alt_sel), .bank_irq(bank_irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) rd_fire <= rd_issued;

  // monitor: compare read results against the scoreboard
  always @(negedge clk) begin
    if (rd_fire) begin
      item_t it;
      it = sb_q.pop_front();
      n_chk++;
      if (bus_rdata !== it.exp) begin
        n_bad++;
        $display("FAIL %s: rdata=%h expected=%h", it.tag, bus_rdata, it.exp);
      end
    end
  end

  task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [W-1:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    rd_issued = 1;
    @(negedge clk);
    bus_sel = 0; rd_issued = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pins(input logic [W-1:0] v);
    @(negedge clk);
    pins_in = v;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    idle(3);
    chk({15'd0, bank_irq}, 16'h0, "R1 irq during reset");
    @(negedge clk); rst = 0;
    for (int a = 0; a < 7; a++) rd(a[3:0], 16'h0, "R1 register reset value");
    // quiet configuration: all rising-edge, masked, pending cleared
    wr(4'd3, 16'hFFFF); wr(4'd4, 16'hFFFF); wr(4'd5, 16'hFFFF); wr(4'd7, 16'h0);
    rd(4'd7, 16'h0, "R11 clear after setup");
    wr(4'd3, 16'h0); idle(2);
    chk({15'd0, bank_irq}, 16'h0, "R10 no pending no irq");
    // R2 storage registers and pad outputs
    wr(4'd0, 16'h0F0F); wr(4'd1, 16'h1234); wr(4'd2, 16'h8001);
    chk(pad_oe, 16'h0F0F, "R2 pad_oe");
    chk(pad_out, 16'h1234, "R2 pad_out");
    chk(alt_sel, 16'h8001, "R2 alt_sel");
    rd(4'd1, 16'h1234, "R2 output readback");
    rd(4'd2, 16'h8001, "R2 alt readback");
    // R3 pin levels, R12 read-only
    pins(16'hA5A5); idle(3);
    rd(4'd8, 16'hA5A5, "R3 pin levels");
    wr(4'd8, 16'hFFFF);
    rd(4'd8, 16'hA5A5, "R12 levels write ignored");
    pins(16'h0000); idle(4); wr(4'd7, 16'h0);
    rd(4'd7, 16'h0, "R4 falling ignored with rising polarity");
    // R4 rising edge
    pins(16'h0001); idle(4);
    rd(4'd7, 16'h0001, "R4 rising edge pending");
    chk({15'd0, bank_irq}, 16'h1, "R10 irq with unmasked pending");
    wr(4'd7, 16'h0); pins(16'h0000); idle(4);
    rd(4'd7, 16'h0, "R4 falling does not set rising pin");
    // R6 sticky
    pins(16'h0002); idle(2); pins(16'h0000); idle(4);
    rd(4'd7, 16'h0002, "R6 edge pending sticky");
    wr(4'd7, 16'h0);
    // R5 falling edge on pin 4
    wr(4'd5, 16'hFFEF);
    pins(16'h0010); idle(4);
    rd(4'd7, 16'h0, "R5 rising ignored on falling pin");
    pins(16'h0000); idle(4);
    rd(4'd7, 16'h0010, "R5 falling edge pending");
    // R11 nonzero write ignored
    wr(4'd7, 16'h1234);
    rd(4'd7, 16'h0010, "R11 nonzero write ignored");
    wr(4'd7, 16'h0);
    rd(4'd7, 16'h0, "R11 zero write clears");
    // R9 mask
    wr(4'd3, 16'h0100);
    pins(16'h0100); idle(4);
    rd(4'd7, 16'h0100, "R9 masked pin still pending");
    chk({15'd0, bank_irq}, 16'h0, "R9 masked irq low");
    wr(4'd3, 16'h0); idle(2);
    chk({15'd0, bank_irq}, 16'h1, "R9 unmask raises irq");
    wr(4'd7, 16'h0); idle(2);
    chk({15'd0, bank_irq}, 16'h0, "R10 irq drops after clear");
    pins(16'h0000); idle(4); wr(4'd7, 16'h0);
    // R7 level high on pin 15
    wr(4'd6, 16'h8000); wr(4'd4, 16'h7FFF);
    rd(4'd7, 16'h0, "R7 inactive level no pending");
    pins(16'h8000); idle(4);
    wr(4'd7, 16'h0);
    rd(4'd7, 16'h8000, "R7 active level survives clear");
    pins(16'h0000); idle(4); wr(4'd7, 16'h0);
    rd(4'd7, 16'h0, "R7 released level clears");
    // R8 level low on pin 14
    pins(16'h4000); idle(4);
    wr(4'd4, 16'h3FFF); wr(4'd7, 16'h0);
    rd(4'd7, 16'h0, "R8 high input no pending");
    pins(16'h0000); idle(4);
    rd(4'd7, 16'h4000, "R8 low input pending");
    pins(16'h4000); idle(4); wr(4'd7, 16'h0);
    rd(4'd7, 16'h0, "R8 cleared once high");
    idle(3);
    finish_run();
  end
endmodule